// File: doc/BRIEF.md
# Two-Channel Audio Serial Port (I2S / PCM)

This block moves stereo audio between parallel sample words and a three-wire serial link made of a bit clock, a frame or word-select line and a data line, in both directions at once. One frame is 64 bit clocks long, split into a left and a right slot of 32 bit clocks each. Samples are 16 to 32 bits wide, sent and received most significant bit first, and sit right-aligned in 32-bit parallel words. The port uses either I2S framing or PCM framing. One static configuration bit picks between them, so the two never run together.

When it drives the clocks, the port divides its system clock by an even ratio to make the bit clock and produces the frame line itself. When it follows a link partner, it synchronises the partner's bit clock and frame line into its own clock domain and locks its frame counter to the detected frame start. In both roles, transmit data changes on bit clock falling edges and receive data is sampled on rising edges. If no transmit sample is offered when a frame starts, the port sends zeros for that frame and raises an underrun flag.

Top module: `audio_serial_port`

## Requirements
- R1: `cfg_width` (16..32) sets the sample width. Only the low `cfg_width` bits of each parallel word travel, MSB first. Slot bits past the sample are 0 on transmit and ignored on receive. Received words are right-aligned with zeros above.
- R2: With `cfg_master`=1, `sclk_out` toggles every `cfg_half` system clocks, so the bit clock is the system clock divided by 2*`cfg_half`. It is high during reset, and its first toggle after reset is a falling edge that begins frame position 0.
- R3: With `cfg_master`=0, timing comes from `sclk_in` and `fs_in` after a two-stage synchroniser, and `sclk_out` and `fs_out` stay low. `sd_out` follows each `sclk_in` falling edge three system clocks after the edge reaches the input.
- R4: I2S normal (`cfg_pcm`=0, `cfg_fmt`=0): word-select is low at positions 0..31 (left) and high at 32..63 (right). It changes only at positions 0 and 32, and each channel's data starts one bit clock after the word-select edge.
- R5: I2S left-justified (`cfg_fmt`=1): each channel's MSB falls on the bit clock where word-select changes.
- R6: I2S right-justified (`cfg_fmt`=2): each channel's LSB falls on the last bit clock of its slot (positions 31 and 63).
- R7: PCM (`cfg_pcm`=1): the frame pulse is high for exactly one bit clock, at position 0. The left MSB is sent at position `cfg_fmt` (0 early, 1..3 late1..late3), and the right MSB follows 32 bit clocks after the left MSB.
- R8: `sd_out` changes only after a bit clock falling edge. `sd_in` is sampled on rising edges.
- R9: When the left slot starts, a pair is taken if `tx_valid` is high. `tx_ready` is high for that one cycle. If `tx_valid` is low, the whole frame sends zeros and `underrun` stays high until the next slot start that takes a sample.
- R10: After the last bit of a frame is received, `rx_left`/`rx_right` are updated and `rx_valid` rises. These outputs hold steady while `rx_ready` is low, and `rx_valid` clears on the cycle after it is seen with `rx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | 1: drive bit clock and frame line; 0: follow them |
| cfg_pcm | input | 1 | 1: PCM framing; 0: I2S framing |
| cfg_fmt | input | 2 | I2S: 0 normal, 1 left-justified, 2 right-justified; PCM: data delay 0..3 |
| cfg_width | input | 6 | Sample width in bits, 16..32 |
| cfg_half | input | DIV_W | Half bit-clock period in system clocks (master role), at least 1 |
| sclk_in | input | 1 | External bit clock (follower role) |
| fs_in | input | 1 | External frame / word-select (follower role) |
| sd_in | input | 1 | Serial receive data |
| sclk_out | output | 1 | Generated bit clock |
| fs_out | output | 1 | Generated frame / word-select |
| sd_out | output | 1 | Serial transmit data |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit pair taken this cycle |
| tx_left | input | 32 | Left transmit sample, right-aligned |
| tx_right | input | 32 | Right transmit sample, right-aligned |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Received pair consumed |
| rx_left | output | 32 | Left received sample, right-aligned |
| rx_right | output | 32 | Right received sample, right-aligned |
| underrun | output | 1 | Current frame is sending zeros for lack of data |

## Verification
Two events can land on the same rising edge: completing a received frame and re-locking onto a new frame start. In I2S normal mode with 32-bit samples, the right channel's LSB arrives in position 0 of the next frame, which is the same edge where the falling word-select marks that frame's start. That 32-bit normal configuration forces the case, and the received pair queue judges it: each pair driven serially must come back intact, with none lost or duplicated. A second overlap is a transmit slot start with no sample offered while the receive side is mid-frame. Dropping `tx_valid` in the middle of a frame provokes it, and the cycle-level model's `sd_out` and `underrun` streams judge it.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_pcm,
  input  logic [1:0]       cfg_fmt,
  input  logic [5:0]       cfg_width,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             sclk_in,
  input  logic             fs_in,
  input  logic             sd_in,
  output logic             sclk_out,
  output logic             fs_out,
  output logic             sd_out,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [31:0]      tx_left,
  input  logic [31:0]      tx_right,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [31:0]      rx_left,
  output logic [31:0]      rx_right,
  output logic             underrun
);
  localparam int POS_W = 6;

  logic [DIV_W-1:0] divcnt;
  logic             sclk_q, fs_q, fs_prev, lock, armed;
  logic [2:0]       sck_s;
  logic [1:0]       fs_s, sd_s;
  logic [POS_W-1:0] bcnt, nb, off, qf, qr, pr;
  logic [31:0]      tx_l, tx_r, rx_sl, rx_sr, word_f;
  logic             tick, fall, rise, fs_cur, sd_cur, start, load, cap, kf_ok, kr_ok;
  logic [4:0]       idx_f;

  assign tick   = cfg_master && (divcnt == cfg_half - DIV_W'(1));
  assign fall   = cfg_master ? (tick && sclk_q)  : (sck_s[2] && !sck_s[1]);
  assign rise   = cfg_master ? (tick && !sclk_q) : (sck_s[1] && !sck_s[2]);
  assign fs_cur = cfg_master ? fs_q  : fs_s[1];
  assign sd_cur = cfg_master ? sd_in : sd_s[1];

  assign off = cfg_pcm ? {4'b0, cfg_fmt} :
               (cfg_fmt == 2'd1) ? 6'd0 :
               (cfg_fmt == 2'd2) ? 6'd32 - cfg_width : 6'd1;

  assign nb    = bcnt + 6'd1;
  assign qf    = nb - off;
  assign start = rise && (cfg_pcm ? (fs_cur && !fs_prev) : (fs_prev && !fs_cur));
  assign pr    = start ? 6'd0 : bcnt;
  assign qr    = pr - off;
  assign kf_ok = {1'b0, qf[4:0]} < cfg_width;
  assign kr_ok = {1'b0, qr[4:0]} < cfg_width;
  assign load  = fall && (qf == 6'd0);
  assign cap   = rise && (qr == 6'd63) && armed;

  assign word_f = load ? (tx_valid ? tx_left : 32'd0) : (qf[5] ? tx_r : tx_l);
  assign idx_f  = 5'(cfg_width - 6'd1 - {1'b0, qf[4:0]});

  assign tx_ready = load;
  assign sclk_out = cfg_master && sclk_q;
  assign fs_out   = cfg_master && fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divcnt   <= '0;
      sclk_q   <= 1'b1;
      fs_q     <= !cfg_pcm;
      fs_prev  <= !cfg_pcm;
      bcnt     <= 6'd63;
      lock     <= 1'b0;
      armed    <= 1'b0;
      sck_s    <= 3'b111;
      fs_s     <= '0;
      sd_s     <= '0;
      sd_out   <= 1'b0;
      underrun <= 1'b0;
      tx_l     <= '0;
      tx_r     <= '0;
      rx_sl    <= '0;
      rx_sr    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      sck_s <= {sck_s[1:0], sclk_in};
      fs_s  <= {fs_s[0], fs_in};
      sd_s  <= {sd_s[0], sd_in};

      if (cfg_master) begin
        if (tick) begin
          divcnt <= '0;
          sclk_q <= !sclk_q;
        end else begin
          divcnt <= divcnt + DIV_W'(1);
        end
      end

      if (fall) begin
        bcnt   <= nb;
        fs_q   <= cfg_pcm ? (nb == 6'd0) : nb[5];
        sd_out <= kf_ok && word_f[idx_f];
        if (load) begin
          tx_l     <= tx_valid ? tx_left  : 32'd0;
          tx_r     <= tx_valid ? tx_right : 32'd0;
          underrun <= !tx_valid;
        end
      end

      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (rise) begin
        fs_prev <= fs_cur;
        if (start) begin
          bcnt <= 6'd0;
          lock <= 1'b1;
        end
        if (qr == 6'd0) begin
          rx_sl <= {31'd0, sd_cur};
          rx_sr <= '0;
          armed <= lock || start;
        end else if (kr_ok) begin
          if (qr[5]) rx_sr <= {rx_sr[30:0], sd_cur};
          else       rx_sl <= {rx_sl[30:0], sd_cur};
        end
        if (cap) begin
          rx_left  <= rx_sl;
          rx_right <= kr_ok ? {rx_sr[30:0], sd_cur} : rx_sr;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  assert_bclk_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !tick) |=> $stable(sclk_out));

  assert_ws_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_pcm && !$stable(fs_out)) |-> (bcnt == 6'd0 || bcnt == 6'd32));

  assert_sync_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_pcm && fs_out && fall) |=> !fs_out);

  assert_tx_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sd_out));

  assert_underrun_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !tx_valid) |=> (underrun && !sd_out));

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !cap) |=> (rx_valid && $stable(rx_left) && $stable(rx_right)));
endmodule

// File: tb/test_audio_serial_port.sv
`timescale 1ns/1ps
module test_audio_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_pcm = 1'b0;
  logic [1:0] cfg_fmt = 2'd0;
  logic [5:0] cfg_width = 6'd16;
  logic [7:0] cfg_half = 8'd2;
  logic sclk_in = 1'b1, fs_in = 1'b1, sd_in = 1'b0;
  logic sclk_out, fs_out, sd_out, tx_ready, rx_valid, underrun;
  logic tx_valid;
  logic rx_ready = 1'b1;
  logic [31:0] tx_left, tx_right, rx_left, rx_right;

  always #10 clk = !clk;

  audio_serial_port #(.DIV_W(8)) i_audio_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pcm(cfg_pcm),
    .cfg_fmt(cfg_fmt), .cfg_width(cfg_width), .cfg_half(cfg_half),
    .sclk_in(sclk_in), .fs_in(fs_in), .sd_in(sd_in),
    .sclk_out(sclk_out), .fs_out(fs_out), .sd_out(sd_out),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right),
    .underrun(underrun));

  int checks = 0, errors = 0;
  bit active = 0, done = 0, tx_en = 1, pend = 0, rxv_prev = 0;
  int half = 2, ntx = 0, nrx = 0;
  int mdiv, mpos;
  bit msclk, mfs, msd, mund;
  logic [31:0] mL, mR, rxL, rxR;
  logic [3:0] sd_h, un_h;
  logic [63:0] exp_q[$];
  string ftag;

  assign tx_valid = tx_en;
  assign tx_left  = 32'h9E37_79B9 * (ntx + 1) ^ 32'h0F1E_2D3C;
  assign tx_right = 32'h7F4A_7C15 * (ntx + 3) ^ 32'hC3B2_A190;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int offset();
    if (cfg_pcm) return int'(cfg_fmt);
    if (cfg_fmt == 2'd1) return 0;
    if (cfg_fmt == 2'd2) return 32 - int'(cfg_width);
    return 1;
  endfunction

  function automatic bit sbit(input logic [31:0] w, input int k);
    if (k < int'(cfg_width)) return w[int'(cfg_width) - 1 - k];
    return 1'b0;
  endfunction

  function automatic logic [31:0] wmask();
    if (cfg_width >= 6'd32) return 32'hFFFF_FFFF;
    return (32'd1 << cfg_width) - 32'd1;
  endfunction

  // behavioural reference: external-role clock generator and expected serial streams
  always @(posedge clk) begin
    int q;
    if (!rst_n) begin
      mdiv = 0; msclk = 1; mpos = 63; mfs = !cfg_pcm; msd = 0; mund = 0;
      mL = 0; mR = 0; rxL = 0; rxR = 0; sd_h = 0; un_h = 0;
    end else begin
      if (mdiv == half - 1) begin
        mdiv = 0;
        if (msclk) begin
          msclk = 0;
          mpos = (mpos + 1) % 64;
          mfs = cfg_pcm ? (mpos == 0) : (mpos >= 32);
          q = (mpos - offset() + 64) % 64;
          if (q == 0) begin
            if (tx_valid) begin mL = tx_left; mR = tx_right; mund = 0; end
            else begin mL = 0; mR = 0; mund = 1; end
            nrx++;
            rxL = 32'hA5A5_3C3C ^ (32'h0101_0101 * nrx) ^ (32'h8000_0001 << (nrx % 7));
            rxR = 32'h5AC3_F00F ^ (32'h0137_9BDF * nrx);
            exp_q.push_back({rxL & wmask(), rxR & wmask()});
          end
          msd = sbit(q < 32 ? mL : mR, q % 32);
        end else begin
          msclk = 1;
        end
      end else begin
        mdiv++;
      end
      sd_h = {sd_h[2:0], msd};
      un_h = {un_h[2:0], mund};
    end
  end

  always @(negedge clk) begin
    int q;
    logic [63:0] e;
    if (pend) ntx++;
    pend = tx_valid && tx_ready;
    q = (mpos - offset() + 64) % 64;
    sclk_in <= msclk;
    fs_in   <= mfs;
    sd_in   <= sbit(q < 32 ? rxL : rxR, q % 32);
    if (active) begin
      if (cfg_master) begin
        chk(sclk_out == msclk, "R2 sclk_out", 64'(sclk_out), 64'(msclk));
        chk(fs_out == mfs, {ftag, " fs_out"}, 64'(fs_out), 64'(mfs));
        chk(sd_out == msd, {ftag, " R1 R8 sd_out"}, 64'(sd_out), 64'(msd));
        chk(underrun == mund, "R9 underrun", 64'(underrun), 64'(mund));
      end else begin
        chk(!sclk_out && !fs_out, "R3 clock outputs low", {sclk_out, fs_out}, 64'd0);
        chk(sd_out == sd_h[3], {ftag, " R3 R8 sd_out"}, 64'(sd_out), 64'(sd_h[3]));
        chk(underrun == un_h[3], "R3 R9 underrun", 64'(underrun), 64'(un_h[3]));
      end
      if (rx_valid && !rxv_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected rx_valid", {rx_left, rx_right}, 64'd0);
        else begin
          e = exp_q.pop_front();
          chk({rx_left, rx_right} == e, {ftag, " R1 R10 rx pair"}, {rx_left, rx_right}, e);
        end
      end
    end
    rxv_prev = rx_valid;
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (mpos != p);
  endtask

  task automatic run_cfg(input bit m, input bit pcm, input int fmt, input int w, input int h,
                         input int frames, input bit gap, input bit hold);
    logic [31:0] held;
    active = 0;
    @(negedge clk);
    rst_n = 0;
    cfg_master = m; cfg_pcm = pcm; cfg_fmt = 2'(fmt); cfg_width = 6'(w); cfg_half = 8'(h);
    half = h; tx_en = 1; rx_ready = 1; ntx = 0; nrx = 0;
    ftag = pcm ? "R7" : (fmt == 0) ? "R4" : (fmt == 1) ? "R5" : "R6";
    repeat (4) @(negedge clk);
    exp_q.delete();
    chk(sclk_out == m, "R2 reset sclk_out", 64'(sclk_out), 64'(m));
    chk(fs_out == (m && !pcm), {ftag, " reset fs_out"}, 64'(fs_out), 64'(m && !pcm));
    chk(!sd_out && !underrun && !tx_ready, "R9 reset outputs", {sd_out, underrun, tx_ready}, 64'd0);
    chk(!rx_valid, "R10 reset rx_valid", 64'(rx_valid), 64'd0);
    rst_n = 1;
    active = 1;
    if (gap) begin
      wait_pos(40); wait_pos(39); wait_pos(40);
      tx_en = 0;
      wait_pos(39); wait_pos(40);
      tx_en = 1;
    end
    if (hold) begin
      wait_pos(40);
      rx_ready = 0;
      do @(negedge clk); while (!rx_valid);
      held = rx_left;
      repeat (6) @(negedge clk);
      chk(rx_valid && rx_left == held, "R10 hold while not ready", {31'd0, rx_valid, rx_left}, {32'd1, held});
      rx_ready = 1;
      @(negedge clk);
      chk(!rx_valid, "R10 clear after ready", 64'(rx_valid), 64'd0);
    end
    repeat (frames * 128 * h) @(negedge clk);
    active = 0;
  endtask

  initial begin
    run_cfg(1, 0, 0, 16, 2, 4, 0, 0);
    run_cfg(1, 0, 1, 24, 3, 3, 0, 0);
    run_cfg(1, 0, 2, 20, 2, 3, 0, 0);
    run_cfg(1, 0, 0, 32, 2, 4, 0, 0);
    run_cfg(1, 1, 0, 32, 2, 3, 0, 0);
    run_cfg(1, 1, 1, 16, 2, 2, 0, 1);
    run_cfg(1, 1, 2, 24, 2, 2, 1, 0);
    run_cfg(1, 1, 3, 28, 1, 4, 0, 0);
    run_cfg(0, 0, 2, 18, 4, 2, 1, 0);
    run_cfg(0, 1, 1, 32, 4, 3, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule